// File: doc/BRIEF.md
# Per-Line GPIO Interrupt Controller

This block turns a bank of already filtered GPIO inputs into one interrupt request per line. Every line carries its own small command/status register. Three configuration inputs per line shape detection. A detect-enable bit switches detection on. A mode bit picks edge (1) or level (0) triggering. An invert bit is XORed onto the input before detection. With the invert bit set, falling-edge or active-low level detection comes from the same rising/high detector.

Software reaches a line's register by presenting the line number with a 4-bit write command. Bit 0 written as 1 acknowledges (clears) the status. Bit 1 written as 1 sets the status as a test. Bit 2 written as 1 clears the enable, and bit 3 written as 1 sets it. A single write of bits 2 and 0 together masks and acknowledges the line at once. The request output of each line is its status gated by its enable.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every status and enable bit is 0, every request output is low, and each line's edge history is 0, so a line held low through reset starts quiet.
- R2: In edge mode (mode bit 1) with detection enabled, a 0-to-1 change of (pin XOR invert) between two consecutive clock edges sets the status. The status is visible at the read port and on the request output after that second edge. A change made only through the invert bit counts as well. An input that stays high sets nothing further.
- R3: In level mode (mode bit 0) with detection enabled, the status is set on every clock edge at which (pin XOR invert) is 1. An acknowledge while the input is active therefore leaves the status at 1.
- R4: With detection disabled, the input never sets the status. The edge history still follows the input, so enabling detection while the input is already high gives no edge event.
- R5: A write with command bit 0 set clears the status, and a write with command bit 1 set sets it. When a set (detection event or bit 1) and a clear happen in the same cycle, the status ends at 1.
- R6: Command bit 3 sets the enable and command bit 2 clears it. Bits 2 and 0 together mask and acknowledge in one write. If bits 3 and 2 are both set, the enable ends at 1.
- R7: The request output of a line is 1 exactly when its status and enable are both 1. The read port returns the status in bit 0, the enable in bit 3, and 0 in bits 1 and 2.
- R8: A write changes only the register of the line it addresses. An event on one line changes no other line's status or request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in | input | NLINES | Filtered input level per line |
| cfg_det_en | input | NLINES | Detection enable per line |
| cfg_edge | input | NLINES | 1 = edge mode, 0 = level mode |
| cfg_invert | input | NLINES | Input invert (XOR) per line |
| wr_en | input | 1 | Register write strobe |
| wr_line | input | LW | Line addressed by the write |
| wr_cmd | input | 4 | Write command: bit0 ack, bit1 set status, bit2 clear enable, bit3 set enable |
| rd_line | input | LW | Line addressed by the read |
| rd_data | output | 4 | Read value: bit0 status, bit3 enable |
| irq | output | NLINES | Interrupt request per line |

## Verification
The assertions assume the pin, configuration and command inputs are synchronous to the clock and stable around its rising edge. They also assume the pins are held low while reset is released, so edge history and input agree from the first active cycle. The bench drives every input on the falling edge and keeps the pins low through reset. It samples results on the next falling edge after the rising edge that acts on them.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int CMD_W      = 4;
  localparam int CMD_ACK    = 0;
  localparam int CMD_SET    = 1;
  localparam int CMD_EN_CLR = 2;
  localparam int CMD_EN_SET = 3;
  localparam int RD_ST_BIT  = 0;
  localparam int RD_EN_BIT  = 3;
endpackage

// File: rtl/gpio_irq_rst_sync.sv
module gpio_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic invert,
  input  logic det_en,
  input  logic edge_mode,
  output logic evt
);
  logic xin;
  logic hist_q;
  logic hist_d;

  always_comb begin
    xin    = pin ^ invert;
    hist_d = xin;
    if (!det_en)        evt = 1'b0;
    else if (edge_mode) evt = xin & ~hist_q;
    else                evt = xin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= hist_d;
  end

  // R2
  edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && xin) |=> !(edge_mode && evt));
endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line
  import gpio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             wr_hit,
  input  logic [CMD_W-1:0] wr_cmd,
  output logic             status,
  output logic             enable
);
  logic st_q, st_d, en_q, en_d;
  logic st_set, st_clr, en_set, en_clr;

  always_comb begin
    st_set = evt | (wr_hit & wr_cmd[CMD_SET]);
    st_clr = wr_hit & wr_cmd[CMD_ACK];
    en_set = wr_hit & wr_cmd[CMD_EN_SET];
    en_clr = wr_hit & wr_cmd[CMD_EN_CLR];
    st_d = st_q;
    if (st_clr) st_d = 1'b0;
    if (st_set) st_d = 1'b1;
    en_d = en_q;
    if (en_clr) en_d = 1'b0;
    if (en_set) en_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= 1'b0;
      en_q <= 1'b0;
    end else begin
      st_q <= st_d;
      en_q <= en_d;
    end
  end

  assign status = st_q;
  assign enable = en_q;

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt || (wr_hit && wr_cmd[CMD_SET])) |=> status);
  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_cmd[CMD_ACK] && !wr_cmd[CMD_SET] && !evt) |=> !status);
  // R6
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_cmd[CMD_EN_SET]) |=> enable);
  // R6
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_cmd[CMD_EN_CLR] && !wr_cmd[CMD_EN_SET]) |=> !enable);
  // R8
  st_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && !wr_hit) |=> ($stable(status) && $stable(enable)));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int LW     = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] pin_in,
  input  logic [NLINES-1:0] cfg_det_en,
  input  logic [NLINES-1:0] cfg_edge,
  input  logic [NLINES-1:0] cfg_invert,
  input  logic              wr_en,
  input  logic [LW-1:0]     wr_line,
  input  logic [CMD_W-1:0]  wr_cmd,
  input  logic [LW-1:0]     rd_line,
  output logic [CMD_W-1:0]  rd_data,
  output logic [NLINES-1:0] irq
);
  logic              rst_s_n;
  logic [NLINES-1:0] evt;
  logic [NLINES-1:0] st;
  logic [NLINES-1:0] en;

  gpio_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic hit;
    assign hit = wr_en && (wr_line == LW'(i));

    gpio_irq_detect u_det (
      .clk(clk), .rst_n(rst_s_n), .pin(pin_in[i]), .invert(cfg_invert[i]),
      .det_en(cfg_det_en[i]), .edge_mode(cfg_edge[i]), .evt(evt[i])
    );

    gpio_irq_line u_reg (
      .clk(clk), .rst_n(rst_s_n), .evt(evt[i]), .wr_hit(hit),
      .wr_cmd(wr_cmd), .status(st[i]), .enable(en[i])
    );
  end

  assign irq = st & en;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NLINES; i++) begin
      if (rd_line == LW'(i)) begin
        rd_data[RD_ST_BIT] = st[i];
        rd_data[RD_EN_BIT] = en[i];
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_s_n |=> (irq == '0));
endmodule

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  localparam int N  = 8;
  localparam int LW = 3;
  localparam int L  = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] pin_in, cfg_det_en, cfg_edge, cfg_invert;
  logic wr_en;
  logic [LW-1:0] wr_line, rd_line;
  logic [3:0] wr_cmd, rd_data;
  logic [N-1:0] irq;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  gpio_irq_ctrl #(.NLINES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_det_en(cfg_det_en),
    .cfg_edge(cfg_edge), .cfg_invert(cfg_invert), .wr_en(wr_en),
    .wr_line(wr_line), .wr_cmd(wr_cmd), .rd_line(rd_line),
    .rd_data(rd_data), .irq(irq)
  );

  // {pin, det, edge, inv, we, cmd[3:0], exp_status, exp_enable}
  localparam logic [10:0] VEC [0:13] = '{
    11'b0_1_1_0_1_1000_0_1,  // R6 enable set
    11'b1_1_1_0_0_0000_1_1,  // R2 rising edge
    11'b1_1_1_0_1_0001_0_1,  // R5 ack, input held high
    11'b0_1_1_0_0_0000_0_1,  // R2 falling pin, no event
    11'b0_1_1_1_0_0000_1_1,  // R2 edge made via invert
    11'b0_1_1_1_1_0101_0_0,  // R6 mask-and-ack
    11'b0_1_1_1_1_0010_1_0,  // R5 test set, R7 masked
    11'b1_1_0_0_1_0001_1_0,  // R3 ack loses to active level
    11'b1_1_0_0_1_1001_1_1,  // R3 R6
    11'b0_1_0_0_1_0001_0_1,  // R3 ack when inactive
    11'b1_0_1_0_0_0000_0_1,  // R4 detection off
    11'b1_1_1_0_0_0000_0_1,  // R4 enable while high
    11'b0_1_1_0_1_1100_0_1,  // R6 both enable bits
    11'b0_1_1_0_1_0100_0_0   // R6 enable clear
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pin_in = '0; cfg_det_en = '0; cfg_edge = '0; cfg_invert = '0;
    wr_en = 1'b0; wr_line = '0; wr_cmd = '0; rd_line = LW'(L);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq", 32'(irq), 32'h0);
    for (int i = 0; i < N; i++) begin
      rd_line = LW'(i);
      #1;
      check("R1 rd_data", 32'(rd_data), 32'h0);
    end
    rd_line = LW'(L);
    wr_line = LW'(L);

    for (int k = 0; k < 14; k++) begin
      logic [10:0] v;
      v = VEC[k];
      pin_in[L] = v[10]; cfg_det_en[L] = v[9]; cfg_edge[L] = v[8];
      cfg_invert[L] = v[7]; wr_en = v[6]; wr_cmd = v[5:2];
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      check($sformatf("R2/R3/R4/R5/R6 vec %0d rd", k), 32'(rd_data),
            32'({v[0], 2'b00, v[1]}));
      check($sformatf("R7 vec %0d irq", k), 32'(irq),
            32'((v[1] & v[0]) << L));
    end

    // R8: write to another line leaves line L alone
    wr_en = 1'b1; wr_line = LW'(5); wr_cmd = 4'b1010;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    check("R8 line5 rd", 32'(rd_data), 32'h0);
    rd_line = LW'(5);
    #1;
    check("R8 line5 set", 32'(rd_data), 32'h9);
    check("R8 irq", 32'(irq), 32'h20);
    // R8: event on line L does not reach line 5 or others
    wr_en = 1'b1; wr_line = LW'(5); wr_cmd = 4'b0101;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    wr_line = LW'(L); wr_en = 1'b1; wr_cmd = 4'b1000;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    pin_in[L] = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 only line3 irq", 32'(irq), 32'h08);
    check("R8 line5 quiet", 32'(rd_data), 32'h0);

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    pin_in = '0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_line = LW'(L);
    #1;
    check("R1 re-reset irq", 32'(irq), 32'h0);
    check("R1 re-reset rd", 32'(rd_data), 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule